// File: doc/BRIEF.md
# Byte-Swapping Bus Endianness Bridge

The bridge connects a big-endian processor core to a little-endian system bus. The core presents a byte address, an access size and right-justified write data, and expects right-justified read data. The bus side sees a word address, per-lane byte enables and full-width data. Lanes are mirrored inside each bus word with no correction for access size. As a result a full-word access keeps its numeric value in both domains. A byte or half-word access lands on the mirrored bytes of the word. For example, a byte at core offset 0 is bus byte 3.

Instruction fetches are full-word reads and take the same path. Firmware images therefore have their bytes reversed within each word before they are placed in memory. The bridge is purely combinational, so read data returns in the same cycle as the bus supplies it. A request that is misaligned or has a reserved size is flagged and is not sent to the bus.

Top module: `endian_bridge`

## Requirements
- R1: A word access (size code 2'b10) at a word-aligned address drives `bus_be_o`=4'b1111, passes `cpu_wdata_i` unchanged to `bus_wdata_o` and `bus_rdata_i` unchanged to `cpu_rdata_o`, and sets `bus_waddr_o` to `cpu_addr_i` shifted right by 2.
- R2: A byte write (size code 2'b00) at core offset k (`cpu_addr_i[1:0]`, 0 to 3) asserts only bus byte enable 3-k. It places `cpu_wdata_i[7:0]` in bus lane 3-k (bits 8(3-k)+7 down to 8(3-k)) and drives zero on every other lane.
- R3: A byte read at core offset k returns bus lane 3-k, zero-extended, on `cpu_rdata_o`.
- R4: A half-word access (size code 2'b01) at offset 0 uses bus lanes 3 and 2 (`bus_be_o`=4'b1100). At offset 2 it uses lanes 1 and 0 (4'b0011). Its 16-bit value maps to those lanes in the same order, so the upper lane of the pair carries the upper byte, for both reads and writes.
- R5: A half-word with `cpu_addr_i[0]`=1, a word with `cpu_addr_i[1:0]`!=0, or size code 2'b11 raises `cpu_align_err_o`. It also holds `bus_req_o`, `bus_we_o`, `bus_be_o`, `bus_wdata_o`, `bus_waddr_o` and `cpu_rdata_o` at zero.
- R6: With `cpu_req_i` low, every output is zero whatever the other inputs carry.
- R7: Read data is steered combinationally: a change on `bus_rdata_i` appears on `cpu_rdata_o` with no clock edge in between.
- R8: An instruction fetch is a word read. A word whose bytes are stored at ascending addresses as DD CC BB AA reaches the core as 0xAABBCCDD.
- R9: `bus_we_o` follows `cpu_we_i` only while a bus transaction is issued, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_req_i | input | 1 | Core access request |
| cpu_we_i | input | 1 | Core write when high, read when low |
| cpu_addr_i | input | ADDR_W (32) | Core byte address |
| cpu_size_i | input | 2 | Access size: 00 byte, 01 half-word, 10 word, 11 reserved |
| cpu_wdata_i | input | 8*LANES (32) | Right-justified core write data |
| cpu_rdata_o | output | 8*LANES (32) | Right-justified, zero-extended core read data |
| cpu_align_err_o | output | 1 | Misaligned or reserved-size request |
| bus_req_o | output | 1 | Bus transaction issued |
| bus_we_o | output | 1 | Bus write strobe |
| bus_waddr_o | output | ADDR_W-2 (30) | Bus word address |
| bus_be_o | output | LANES (4) | Bus byte enables, bit j for lane j |
| bus_wdata_o | output | 8*LANES (32) | Lane-steered bus write data |
| bus_rdata_i | input | 8*LANES (32) | Bus read data |

## Verification
Every result of this bridge is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench therefore changes inputs on the falling clock edge and samples all outputs 2 ns later, inside that same half period. The R7 check goes further: it changes the bus read data with no clock edge in between and samples again 1 ns later. This shows that read data needs no cycle to reach the core.

// File: rtl/endian_bridge_pkg.sv
package endian_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_RSVD  = 2'b11
   } acc_size_e;

   // Encoded size is log2 of the byte count; a code is legal when it does
   // not exceed log2 of the lane count.
   function automatic bit size_legal(input acc_size_e sz, input int lanes_log2);
      return int'(sz) <= lanes_log2 && sz != SZ_RSVD;
   endfunction

endpackage

// File: rtl/ebr_lane_decode.sv
module ebr_lane_decode
   import endian_bridge_pkg::*;
#(
   parameter int LANES = 4,
   localparam int LB   = $clog2(LANES)
) (
   input  logic             req_i,
   input  acc_size_e        size_i,
   input  logic [LB-1:0]    offs_i,
   output logic             issue_o,
   output logic             err_o,
   output logic [LANES-1:0] be_o,
   output logic [LB-1:0]    low_o,
   output logic [LB:0]      nbytes_o
);

   logic          size_ok;
   logic [LB:0]   span;
   logic [LB-1:0] amask;
   logic          aligned;
   int            lo_int;

   always_comb begin
      size_ok  = size_legal(size_i, LB);
      span     = size_ok ? ((LB+1)'(1) << size_i) : '0;
      amask    = LB'(span - (LB+1)'(1));
      aligned  = (offs_i & amask) == '0;
      issue_o  = req_i && size_ok && aligned;
      err_o    = req_i && !issue_o;
      nbytes_o = issue_o ? span : '0;
      // Core offset k maps to bus lane LANES-1-k; the access block's lowest
      // bus lane is therefore LANES - bytes - offset.
      lo_int   = LANES - int'(span) - int'(offs_i);
      low_o    = issue_o ? LB'(lo_int) : '0;
   end

   for (genvar j = 0; j < LANES; j++) begin : g_be
      assign be_o[j] = issue_o
                     && ((LB+1)'(j) >= {1'b0, low_o})
                     && ((LB+1)'(j) <  ({1'b0, low_o} + nbytes_o));
   end

endmodule

// File: rtl/ebr_wr_steer.sv
module ebr_wr_steer #(
   parameter int LANES = 4,
   localparam int LB   = $clog2(LANES),
   localparam int DW   = 8 * LANES
) (
   input  logic [LANES-1:0] be_i,
   input  logic [LB-1:0]    low_i,
   input  logic [DW-1:0]    cpu_wdata_i,
   output logic [DW-1:0]    bus_wdata_o
);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LB-1:0] src;
      assign src = LB'(j) - low_i;
      assign bus_wdata_o[8*j +: 8] = be_i[j] ? cpu_wdata_i[8*src +: 8] : 8'h00;
   end

endmodule

// File: rtl/ebr_rd_steer.sv
module ebr_rd_steer #(
   parameter int LANES = 4,
   localparam int LB   = $clog2(LANES),
   localparam int DW   = 8 * LANES
) (
   input  logic          issue_i,
   input  logic [LB-1:0] low_i,
   input  logic [LB:0]   nbytes_i,
   input  logic [DW-1:0] bus_rdata_i,
   output logic [DW-1:0] cpu_rdata_o
);

   for (genvar i = 0; i < LANES; i++) begin : g_byte
      logic [LB-1:0] lane;
      logic          in_rng;
      assign lane   = LB'(i) + low_i;
      assign in_rng = issue_i && ((LB+1)'(i) < nbytes_i);
      assign cpu_rdata_o[8*i +: 8] = in_rng ? bus_rdata_i[8*lane +: 8] : 8'h00;
   end

endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
   import endian_bridge_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4,
   localparam int LB    = $clog2(LANES),
   localparam int DW    = 8 * LANES
) (
   input  logic              cpu_req_i,
   input  logic              cpu_we_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [1:0]        cpu_size_i,
   input  logic [DW-1:0]     cpu_wdata_i,
   output logic [DW-1:0]     cpu_rdata_o,
   output logic              cpu_align_err_o,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-LB-1:0] bus_waddr_o,
   output logic [LANES-1:0]  bus_be_o,
   output logic [DW-1:0]     bus_wdata_o,
   input  logic [DW-1:0]     bus_rdata_i
);

   if (LANES != 2 && LANES != 4 && LANES != 8) begin : g_bad_lanes
      $error("endian_bridge: LANES must be 2, 4 or 8");
   end
   if (ADDR_W <= LB) begin : g_bad_addr
      $error("endian_bridge: ADDR_W too small for LANES");
   end

   acc_size_e     size;
   logic          issue;
   logic          err;
   logic [LB-1:0] low;
   logic [LB:0]   nbytes;
   logic [LB-1:0] offs;

   assign size = acc_size_e'(cpu_size_i);
   assign offs = cpu_addr_i[LB-1:0];

   ebr_lane_decode #(.LANES(LANES)) dec_i (
      .req_i    (cpu_req_i),
      .size_i   (size),
      .offs_i   (offs),
      .issue_o  (issue),
      .err_o    (err),
      .be_o     (bus_be_o),
      .low_o    (low),
      .nbytes_o (nbytes)
   );

   ebr_wr_steer #(.LANES(LANES)) wr_i (
      .be_i        (bus_be_o),
      .low_i       (low),
      .cpu_wdata_i (cpu_wdata_i),
      .bus_wdata_o (bus_wdata_o)
   );

   ebr_rd_steer #(.LANES(LANES)) rd_i (
      .issue_i     (issue),
      .low_i       (low),
      .nbytes_i    (nbytes),
      .bus_rdata_i (bus_rdata_i),
      .cpu_rdata_o (cpu_rdata_o)
   );

   assign bus_req_o       = issue;
   assign bus_we_o        = issue && cpu_we_i;
   assign cpu_align_err_o = err;
   assign bus_waddr_o     = issue ? cpu_addr_i[ADDR_W-1:LB] : '0;

   // Guards: steering and decode are separate pieces of logic; check them
   // against each other once the inputs carry known values.
   always_comb begin
      if (!$isunknown({cpu_req_i, cpu_we_i, cpu_size_i, offs})) begin
         // R5: flagged requests steer no read data to the core
         assert_err_quiet_R5: assert (!err || (cpu_rdata_o == '0 && bus_be_o == '0))
            else $error("R5: error request leaked data or enables");
         // R9: no write strobe without a transaction
         assert_we_needs_req_R9: assert (!bus_we_o || bus_req_o)
            else $error("R9: write strobe without request");
         // R2: the mirrored lane of the core offset is always enabled
         assert_mirror_lane_R2: assert (!issue || bus_be_o[LANES-1-int'(offs)])
            else $error("R2: mirrored lane not enabled");
         // R4: enabled lane count matches access size
         assert_be_count_R4: assert (!issue || $countones(bus_be_o) == int'(nbytes))
            else $error("R4: enable count mismatch");
         // R6: idle request drives nothing
         assert_idle_R6: assert (cpu_req_i || (!bus_req_o && !cpu_align_err_o && bus_be_o == '0))
            else $error("R6: output active while idle");
      end
   end

endmodule

// File: tb/endian_bridge_tb_top.sv
module endian_bridge_tb_top;

   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        cpu_req, cpu_we;
   logic [31:0] cpu_addr;
   logic [1:0]  cpu_size;
   logic [31:0] cpu_wdata, cpu_rdata;
   logic        cpu_err, bus_req, bus_we;
   logic [29:0] bus_waddr;
   logic [3:0]  bus_be;
   logic [31:0] bus_wdata, bus_rdata;

   endian_bridge dut_i (
      .cpu_req_i       (cpu_req),
      .cpu_we_i        (cpu_we),
      .cpu_addr_i      (cpu_addr),
      .cpu_size_i      (cpu_size),
      .cpu_wdata_i     (cpu_wdata),
      .cpu_rdata_o     (cpu_rdata),
      .cpu_align_err_o (cpu_err),
      .bus_req_o       (bus_req),
      .bus_we_o        (bus_we),
      .bus_waddr_o     (bus_waddr),
      .bus_be_o        (bus_be),
      .bus_wdata_o     (bus_wdata),
      .bus_rdata_i     (bus_rdata)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct packed {
      logic [23:0] tag;
      logic        we;
      logic [1:0]  sz;
      logic [3:0]  off;
      logic [31:0] wd;
      logic [31:0] brd;
      logic [3:0]  be;
      logic [31:0] bwd;
      logic [31:0] crd;
      logic        err;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VT [NV] = '{
      '{"R1 ", 1'b0, 2'b10, 4'h0, 32'h0,        32'h12345678, 4'hF, 32'h0,        32'h12345678, 1'b0},
      '{"R1 ", 1'b1, 2'b10, 4'h4, 32'hCAFEF00D, 32'h0,        4'hF, 32'hCAFEF00D, 32'h0,        1'b0},
      '{"R4 ", 1'b0, 2'b01, 4'h0, 32'h0,        32'h1234ABCD, 4'hC, 32'h0,        32'h00001234, 1'b0},
      '{"R4 ", 1'b0, 2'b01, 4'h2, 32'h0,        32'h1234ABCD, 4'h3, 32'h0,        32'h0000ABCD, 1'b0},
      '{"R3 ", 1'b0, 2'b00, 4'h0, 32'h0,        32'h43534952, 4'h8, 32'h0,        32'h00000043, 1'b0},
      '{"R3 ", 1'b0, 2'b00, 4'h1, 32'h0,        32'h43534952, 4'h4, 32'h0,        32'h00000053, 1'b0},
      '{"R3 ", 1'b0, 2'b00, 4'h2, 32'h0,        32'h43534952, 4'h2, 32'h0,        32'h00000049, 1'b0},
      '{"R3 ", 1'b0, 2'b00, 4'h3, 32'h0,        32'h43534952, 4'h1, 32'h0,        32'h00000052, 1'b0},
      '{"R2 ", 1'b1, 2'b00, 4'h1, 32'hFFFFFFA5, 32'h0,        4'h4, 32'h00A50000, 32'h0,        1'b0},
      '{"R2 ", 1'b1, 2'b00, 4'h3, 32'h00000011, 32'h0,        4'h1, 32'h00000011, 32'h0,        1'b0},
      '{"R4 ", 1'b1, 2'b01, 4'h0, 32'hDEADBEEF, 32'h0,        4'hC, 32'hBEEF0000, 32'h0,        1'b0},
      '{"R4 ", 1'b1, 2'b01, 4'h2, 32'h00001357, 32'h0,        4'h3, 32'h00001357, 32'h0,        1'b0},
      '{"R5 ", 1'b0, 2'b01, 4'h1, 32'h0,        32'hFFFFFFFF, 4'h0, 32'h0,        32'h0,        1'b1},
      '{"R5 ", 1'b1, 2'b10, 4'h6, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h0, 32'h0,        32'h0,        1'b1},
      '{"R5 ", 1'b0, 2'b11, 4'h0, 32'h0,        32'hFFFFFFFF, 4'h0, 32'h0,        32'h0,        1'b1},
      '{"R8 ", 1'b0, 2'b10, 4'h8, 32'h0,        32'hAABBCCDD, 4'hF, 32'h0,        32'hAABBCCDD, 1'b0}
   };

   localparam logic [31:0] BASE = 32'h2000_0100;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic rq, input logic we, input logic [1:0] sz,
                        input logic [31:0] ad, input logic [31:0] wd,
                        input logic [31:0] brd);
      @(negedge clk);
      cpu_req = rq; cpu_we = we; cpu_size = sz;
      cpu_addr = ad; cpu_wdata = wd; bus_rdata = brd;
      #2;
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20000 * 10);
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      cpu_req = 0; cpu_we = 0; cpu_size = 0; cpu_addr = 0;
      cpu_wdata = 0; bus_rdata = 0;
      #2;
      // Reset / idle state (R6)
      chk("R6", "bus_req idle", {31'b0, bus_req}, 32'h0);
      chk("R6", "be idle", {28'b0, bus_be}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         automatic vec_t v = VT[i];
         automatic logic [31:0] ad = BASE + {28'b0, v.off};
         automatic string t = $sformatf("%s", v.tag);
         drive(1'b1, v.we, v.sz, ad, v.wd, v.brd);
         chk(t, "bus_be",    {28'b0, bus_be}, {28'b0, v.be});
         chk(t, "bus_wdata", bus_wdata, v.bwd);
         chk(t, "cpu_rdata", cpu_rdata, v.crd);
         chk(t, "align_err", {31'b0, cpu_err}, {31'b0, v.err});
         chk(t, "bus_req",   {31'b0, bus_req}, {31'b0, !v.err});
         chk("R9", "bus_we", {31'b0, bus_we}, {31'b0, v.we && !v.err});
         chk(t, "bus_waddr", {2'b0, bus_waddr}, v.err ? 32'h0 : {2'b0, ad[31:2]});
      end

      // R6: no request, busy inputs: all outputs quiet
      drive(1'b0, 1'b1, 2'b10, BASE, 32'hFFFFFFFF, 32'hFFFFFFFF);
      chk("R6", "bus_wdata idle", bus_wdata, 32'h0);
      chk("R6", "cpu_rdata idle", cpu_rdata, 32'h0);
      chk("R6", "bus_we idle", {31'b0, bus_we}, 32'h0);
      chk("R6", "err idle", {31'b0, cpu_err}, 32'h0);

      // R7: read data follows bus without a clock edge
      drive(1'b1, 1'b0, 2'b00, BASE + 32'd2, 32'h0, 32'h0000_7700);
      chk("R7", "byte rd before", cpu_rdata, 32'h00000077);
      bus_rdata = 32'h0000_3C00;
      #1;
      chk("R7", "byte rd same cycle", cpu_rdata, 32'h0000003C);

      // R9 with R5: misaligned write issues no write strobe
      drive(1'b1, 1'b1, 2'b01, BASE + 32'd3, 32'hFFFF, 32'h0);
      chk("R9", "bus_we misaligned", {31'b0, bus_we}, 32'h0);
      chk("R5", "bus_wdata misaligned", bus_wdata, 32'h0);

      summary();
   end

endmodule